// File: doc/BRIEF.md
# Sub-word read adapter for a dword-only register space

This block sits between a bus master that reads 1, 2 or 4 bytes at any byte address and a register space that can only answer full 32-bit reads at dword-aligned addresses. For each accepted request it first checks that the size is one it supports and that the address is a multiple of that size. A legal request becomes exactly one downstream read at the address with its two low bits cleared. The returned word is shifted right by the byte offset and then masked to the requested width before it goes back upstream. A request that fails the check is answered with an error and zero data, and the downstream side never sees it.

Both sides use valid/ready handshakes: a request channel and a response channel upstream, and the same pair downstream. A transfer happens on a rising edge where valid and ready are both high. A valid signal, once raised, stays high with its payload unchanged until its transfer. Only one read is in flight at a time. The upstream request ready is high only while the adapter is idle, so the master is held off from acceptance until its response has been taken. The adapter holds its downstream request and its upstream response for as long as the far side stalls.

Top module: `mmio_subword_rd`

## Requirements
- R1: The downstream request address equals the upstream address with bits 1:0 forced to zero, and exactly one downstream request is issued per legal upstream request.
- R2: A request whose address is not a multiple of its size (size 2 with bit 0 set, size 4 with either of bits 1:0 set) is answered with error set and issues no downstream request.
- R3: The size input is a 3-bit byte count, and only the values 1, 2 and 4 are legal. Any other value (0, 3, 5, 6, 7) is answered with error set and issues no downstream request.
- R4: For a legal read, the downstream word is shifted right by 8 times address bits 1:0 before masking.
- R5: After the shift, a 1-byte read keeps bits 7:0 and a 2-byte read keeps bits 15:0, with all upper bits zero. A 4-byte read passes all 32 bits.
- R6: A rejected request raises response valid on the clock edge right after its acceptance, with error 1 and data 0.
- R7: Once a request is accepted, the upstream request ready stays low until the upstream response transfer completes, so at most one read is outstanding.
- R8: While the upstream response is stalled by a low response ready, response valid, data and error hold steady. While the downstream request is stalled, its valid and address hold steady.
- R9: After reset, request ready is high and both response valid and downstream request valid are low.
- R10: A legal read that completes downstream returns error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream read request valid |
| up_req_ready | output | 1 | Adapter can accept a request |
| up_req_addr | input | ADDR_W | Byte address of the read |
| up_req_size | input | SIZE_W | Byte count of the read (1, 2 or 4 legal) |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Master accepts the response |
| up_rsp_data | output | DATA_W | Read data, right-justified and zero-filled |
| up_rsp_err | output | 1 | Request was rejected |
| dn_req_valid | output | 1 | Downstream dword read request valid |
| dn_req_ready | input | 1 | Register space accepts the request |
| dn_req_addr | output | ADDR_W | Dword-aligned downstream address |
| dn_rsp_valid | input | 1 | Downstream read data valid |
| dn_rsp_ready | output | 1 | Adapter accepts the downstream data |
| dn_rsp_data | input | DATA_W | Full downstream word |

## Verification
The downstream model returns a word whose four bytes all differ and depend on the address, so a wrong shift, a wrong mask or a wrong dword address each gives a distinct wrong value. Byte reads at all four offsets and halfword reads at both legal offsets show that the shift amount follows the low address bits. Full-word reads show that nothing is masked off. Misaligned halfword and word reads, and every illegal size code, show that rejection depends on both alignment and size, and that no downstream request is issued for them. A pass with a slow downstream side and a stalled upstream response shows that the response holds while stalled and that no second request is accepted early.

// File: rtl/mmio_rd_pkg.sv
package mmio_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DREQ = 2'd1,
    ST_DRSP = 2'd2,
    ST_URSP = 2'd3
  } rd_state_e;
endpackage

// File: rtl/mmio_rd_align_chk.sv
// Decides legality of a request: size must be a power of two no wider than
// the data bus, and the address must be naturally aligned for that size.
module mmio_rd_align_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              legal,
  output logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] base
);
  logic [OFF_W:0] hit;

  for (genvar k = 0; k <= OFF_W; k++) begin : g_size
    assign hit[k] = (size == SIZE_W'(1 << k)) &&
                    ((addr[OFF_W-1:0] & OFF_W'((1 << k) - 1)) == '0);
  end

  assign legal  = |hit;
  assign offset = addr[OFF_W-1:0];
  assign base   = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/mmio_rd_lane_sel.sv
// Shifts the full word right by the byte offset and zeroes bytes beyond size.
module mmio_rd_lane_sel #(
  parameter int LANES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  offset,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;

  assign shifted = word >> {offset, 3'b000};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign result[j*8 +: 8] = (size > SIZE_W'(j)) ? shifted[j*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/mmio_rd_ctrl.sv
// Sequencer: one read in flight, request ready only when idle.
module mmio_rd_ctrl
  import mmio_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      up_req_valid,
  input  logic      req_legal,
  input  logic      dn_req_ready,
  input  logic      dn_rsp_valid,
  input  logic      up_rsp_ready,
  output rd_state_e state,
  output logic      up_req_ready,
  output logic      dn_req_valid,
  output logic      dn_rsp_ready,
  output logic      up_rsp_valid,
  output logic      take_req,
  output logic      take_rej,
  output logic      take_rsp
);
  rd_state_e nxt;

  assign up_req_ready = (state == ST_IDLE);
  assign dn_req_valid = (state == ST_DREQ);
  assign dn_rsp_ready = (state == ST_DRSP);
  assign up_rsp_valid = (state == ST_URSP);

  assign take_req = up_req_ready && up_req_valid && req_legal;
  assign take_rej = up_req_ready && up_req_valid && !req_legal;
  assign take_rsp = dn_rsp_ready && dn_rsp_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (take_req) nxt = ST_DREQ;
               else if (take_rej) nxt = ST_URSP;
      ST_DREQ: if (dn_req_ready) nxt = ST_DRSP;
      ST_DRSP: if (dn_rsp_valid) nxt = ST_URSP;
      ST_URSP: if (up_rsp_ready) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/mmio_subword_rd.sv
module mmio_subword_rd
  import mmio_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [SIZE_W-1:0] up_req_size,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_data
);
  rd_state_e         state;
  logic              legal, take_req, take_rej, take_rsp;
  logic [OFF_W-1:0]  off_c, off_q;
  logic [ADDR_W-1:0] base_c, base_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] sel_data, data_q;
  logic              err_q;

  mmio_rd_align_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .SIZE_W(SIZE_W)) u_align (
    .addr   (up_req_addr),
    .size   (up_req_size),
    .legal  (legal),
    .offset (off_c),
    .base   (base_c)
  );

  mmio_rd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .req_legal    (legal),
    .dn_req_ready (dn_req_ready),
    .dn_rsp_valid (dn_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .state        (state),
    .up_req_ready (up_req_ready),
    .dn_req_valid (dn_req_valid),
    .dn_rsp_ready (dn_rsp_ready),
    .up_rsp_valid (up_rsp_valid),
    .take_req     (take_req),
    .take_rej     (take_rej),
    .take_rsp     (take_rsp)
  );

  mmio_rd_lane_sel #(.LANES(LANES), .SIZE_W(SIZE_W)) u_lanes (
    .word   (dn_rsp_data),
    .offset (off_q),
    .size   (size_q),
    .result (sel_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      size_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (take_req) begin
        base_q <= base_c;
        off_q  <= off_c;
        size_q <= up_req_size;
      end
      if (take_rej) begin
        data_q <= '0;
        err_q  <= 1'b1;
      end else if (take_rsp) begin
        data_q <= sel_data;
        err_q  <= 1'b0;
      end
    end
  end

  assign dn_req_addr = base_q;
  assign up_rsp_data = data_q;
  assign up_rsp_err  = err_q;
endmodule

// File: rtl/mmio_subword_rd_chk.sv
module mmio_subword_rd_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic [ADDR_W-1:0] up_req_addr,
  input logic [SIZE_W-1:0] up_req_size,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [DATA_W-1:0] up_rsp_data,
  input logic              up_rsp_err,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic              dn_rsp_valid,
  input logic              dn_rsp_ready
);
  logic ok_req;
  always_comb begin
    ok_req = 1'b0;
    if (up_req_size == SIZE_W'(1)) ok_req = 1'b1;
    if (up_req_size == SIZE_W'(2) && !up_req_addr[0]) ok_req = 1'b1;
    if (up_req_size == SIZE_W'(4) && up_req_addr[1:0] == 2'b00) ok_req = 1'b1;
  end

  AST_DN_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> dn_req_addr[1:0] == 2'b00); // R1

  AST_REJECT_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready && !ok_req) |=> !dn_req_valid); // R2

  AST_REJECT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready && !ok_req) |=>
      (up_rsp_valid && up_rsp_err && up_rsp_data == '0)); // R6

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_ready |-> (!up_rsp_valid && !dn_req_valid && !dn_rsp_ready)); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      (up_rsp_valid && $stable(up_rsp_data) && $stable(up_rsp_err))); // R8

  AST_DN_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr))); // R8

  AST_GOOD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rsp_valid && dn_rsp_ready) |=> (up_rsp_valid && !up_rsp_err)); // R10
endmodule

bind mmio_subword_rd mmio_subword_rd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_req_valid (up_req_valid),
  .up_req_ready (up_req_ready),
  .up_req_addr  (up_req_addr),
  .up_req_size  (up_req_size),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_ready (up_rsp_ready),
  .up_rsp_data  (up_rsp_data),
  .up_rsp_err   (up_rsp_err),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_addr  (dn_req_addr),
  .dn_rsp_valid (dn_rsp_valid),
  .dn_rsp_ready (dn_rsp_ready)
);

// File: tb/mmio_subword_rd_bench.sv
module mmio_subword_rd_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req_valid = 1'b0;
  logic        up_req_ready;
  logic [31:0] up_req_addr = '0;
  logic [2:0]  up_req_size = '0;
  logic        up_rsp_valid;
  logic        up_rsp_ready = 1'b0;
  logic [31:0] up_rsp_data;
  logic        up_rsp_err;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic [31:0] dn_req_addr;
  logic        dn_rsp_valid = 1'b0;
  logic        dn_rsp_ready;
  logic [31:0] dn_rsp_data = '0;

  int checks = 0;
  int failures = 0;
  int dn_cnt = 0;
  logic [31:0] dn_last_addr = '0;
  int dn_stall = 0;
  int dn_lat = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_subword_rd u_mmio_subword_rd (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_req_addr(up_req_addr), .up_req_size(up_req_size),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_data(up_rsp_data), .up_rsp_err(up_rsp_err),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_addr(dn_req_addr), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_ready(dn_rsp_ready), .dn_rsp_data(dn_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] ^ 8'hD4, a[7:0] ^ 8'h93, a[7:0] ^ 8'h6B, a[7:0] ^ 8'h2E};
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Downstream register-space model
  initial begin
    forever begin
      @(negedge clk);
      if (dn_req_valid) begin
        repeat (dn_stall) @(negedge clk);
        dn_req_ready = 1'b1;
        dn_last_addr = dn_req_addr;
        dn_cnt++;
        @(negedge clk);
        dn_req_ready = 1'b0;
        repeat (dn_lat) @(negedge clk);
        dn_rsp_valid = 1'b1;
        dn_rsp_data  = mem_word(dn_last_addr);
        while (!dn_rsp_ready) @(negedge clk);
        @(negedge clk);
        dn_rsp_valid = 1'b0;
        dn_rsp_data  = '0;
      end
    end
  end

  task automatic do_read(input logic [31:0] addr, input logic [2:0] size,
                         input int rsp_stall);
    bit          ok;
    logic [31:0] exp;
    logic [31:0] held;
    logic        held_err;
    int          cnt0;
    int          guard;
    ok = (size == 3'd1) || (size == 3'd2 && !addr[0]) ||
         (size == 3'd4 && addr[1:0] == 2'b00);
    exp = mem_word({addr[31:2], 2'b00}) >> (addr[1:0] * 8);
    if (size == 3'd1) exp = exp & 32'h0000_00FF;
    else if (size == 3'd2) exp = exp & 32'h0000_FFFF;
    cnt0 = dn_cnt;
    @(negedge clk);
    up_req_valid = 1'b1;
    up_req_addr  = addr;
    up_req_size  = size;
    @(negedge clk);
    up_req_valid = 1'b0;
    if (!ok) begin
      chk(up_rsp_valid, "R6", "reject response next cycle", {31'b0, up_rsp_valid}, 32'd1);
      chk(!dn_req_valid, size inside {3'd1, 3'd2, 3'd4} ? "R2" : "R3",
          "no downstream request valid", {31'b0, dn_req_valid}, 32'd0);
    end else begin
      guard = 0;
      while (!up_rsp_valid && guard < 100) begin
        @(negedge clk);
        guard++;
      end
      chk(!up_req_ready, "R7", "request ready low while response pending",
          {31'b0, up_req_ready}, 32'd0);
      chk(dn_last_addr == {addr[31:2], 2'b00}, "R1", "downstream address",
          dn_last_addr, {addr[31:2], 2'b00});
    end
    held = up_rsp_data;
    held_err = up_rsp_err;
    for (int i = 0; i < rsp_stall; i++) begin
      @(negedge clk);
      chk(up_rsp_valid && up_rsp_data == held && up_rsp_err == held_err && !up_req_ready,
          "R8", "response hold under stall", up_rsp_data, held);
    end
    if (ok) begin
      chk(dn_cnt == cnt0 + 1, "R1", "one downstream request", dn_cnt, cnt0 + 1);
      chk(up_rsp_err == 1'b0, "R10", "no error on legal read", {31'b0, up_rsp_err}, 32'd0);
      chk(up_rsp_data == exp, size == 3'd4 ? "R4" : "R5", "shifted/masked data",
          up_rsp_data, exp);
    end else begin
      chk(dn_cnt == cnt0, size inside {3'd1, 3'd2, 3'd4} ? "R2" : "R3",
          "no downstream request count", dn_cnt, cnt0);
      chk(up_rsp_err == 1'b1, size inside {3'd1, 3'd2, 3'd4} ? "R2" : "R3",
          "error flag", {31'b0, up_rsp_err}, 32'd1);
      chk(up_rsp_data == '0, "R6", "reject data zero", up_rsp_data, 32'd0);
    end
    up_rsp_ready = 1'b1;
    @(negedge clk);
    up_rsp_ready = 1'b0;
    chk(up_req_ready && !up_rsp_valid, "R7", "idle after response transfer",
        {31'b0, up_req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(up_req_ready, "R9", "request ready after reset", {31'b0, up_req_ready}, 32'd1);
    chk(!up_rsp_valid, "R9", "response valid after reset", {31'b0, up_rsp_valid}, 32'd0);
    chk(!dn_req_valid, "R9", "downstream valid after reset", {31'b0, dn_req_valid}, 32'd0);
  endtask

  task automatic t_words();
    do_read(32'h0000_0100, 3'd4, 0);      // R4 full word
    do_read(32'h0000_1A3C, 3'd4, 0);
  endtask

  task automatic t_halves();
    do_read(32'h0000_0100, 3'd2, 0);      // R5 low half
    do_read(32'h0000_0102, 3'd2, 0);      // R4 upper half shifted
  endtask

  task automatic t_bytes();
    for (int o = 0; o < 4; o++) do_read(32'h0000_0240 + o, 3'd1, 0); // R4 R5
  endtask

  task automatic t_misaligned();
    do_read(32'h0000_0101, 3'd2, 0);      // R2
    do_read(32'h0000_0103, 3'd2, 0);      // R2
    do_read(32'h0000_0102, 3'd4, 0);      // R2
    do_read(32'h0000_0101, 3'd4, 0);      // R2
  endtask

  task automatic t_bad_sizes();
    do_read(32'h0000_0200, 3'd0, 0);      // R3
    do_read(32'h0000_0200, 3'd3, 0);      // R3
    do_read(32'h0000_0200, 3'd5, 0);      // R3
    do_read(32'h0000_0200, 3'd6, 1);      // R3
    do_read(32'h0000_0200, 3'd7, 0);      // R3
  endtask

  task automatic t_backpressure();
    dn_stall = 3;
    dn_lat   = 2;
    do_read(32'h0000_0345, 3'd1, 3);      // R8
    do_read(32'h0000_0346, 3'd2, 2);      // R8
    do_read(32'h0000_0348, 3'd4, 4);      // R8
    dn_stall = 0;
    dn_lat   = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_words();
    t_halves();
    t_bytes();
    t_misaligned();
    t_bad_sizes();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule